// File: doc/BRIEF.md
# Predicated SIMD Lane Datapath

This block is a vector execution unit. It works on 128-bit vectors that are split into eight independent 16-bit lanes. Every lane has a one-bit predicate flag stored next to it. A compare writes these flags. Each later operation carries a two-bit condition field, and that field decides, lane by lane, whether the lane's result is written back to the destination. A conditional update therefore needs no spare register to hold a mask.

One operation is accepted per clock when `in_valid` is high. The operation names a destination register, two source registers and an immediate vector. The destination's new contents are registered and shown on `out_data` one cycle later. The lane flags are always visible on `out_flags`. The unit holds a small vector register file. It executes lane-wise add, unsigned greater-or-equal compare, move, bit-mask select, immediate load and a non-writing read.

Top module: `psimd_lane_unit`

## Requirements
- R1: Synchronous active-high reset clears every vector register, every lane flag, `out_data` and `out_valid` to zero.
- R2: The operation code is on `in_op`. Code 4 (load) writes `in_imm` to the destination. Lane l occupies bits 16l+15 down to 16l, and flag l is bit l of `out_flags`.
- R3: Code 0 (add) gives, in each lane, (A + B) mod 2^16. No carry passes between lanes.
- R4: Code 1 (compare) sets flag l to 1 exactly when lane l of A is greater than or equal to lane l of B, both taken as unsigned. This flag update happens whatever the condition field says. Each destination lane is written with 0xFFFF when its new flag is 1 and with 0x0000 when it is 0.
- R5: The condition field `in_cond` is judged against each lane's flag as it was before the operation. 00 writes only the lanes whose flag is 0. 01 writes only the lanes whose flag is 1. 10 and 11 write every lane.
- R6: A lane that is not written keeps its destination value. Every operation other than compare leaves all flags unchanged.
- R7: Code 3 (select) uses register B as a mask. In each written lane, a destination bit takes A's bit where the mask bit is 1 and keeps its old value where the mask bit is 0.
- R8: Code 2 (move) copies A into the written lanes of the destination.
- R9: Codes 5, 6 and 7 (read) write nothing. They report the destination register on `out_data`.
- R10: `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, no state changes and `out_data` holds its value.
- R11: The sequence "A = A + B, then A = D in each lane where A >= C" is reached with three operations: add, compare, and move with condition 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code |
| in_cond | input | 2 | Per-lane writeback condition |
| in_dst | input | 2 | Destination register index |
| in_srca | input | 2 | Source A register index |
| in_srcb | input | 2 | Source B (or mask) register index |
| in_imm | input | 128 | Immediate vector for load |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Destination contents after the operation |
| out_flags | output | 8 | Current lane flags |

## Verification
A compare whose condition field is 00 or 01 does two things in the same cycle. Its own lane predicates gate its mask writeback, and it also rewrites those same predicates. The bench provokes this by following a compare with compares and moves under every condition code, so the old and new flags differ lane by lane. Each result is judged against a model that gates with the flags from before the operation. A long pseudo-random stream mixes all codes and register aliasing, and it also exposes select and compare cases where the destination equals a source.

// File: rtl/psu_pkg.sv
package psu_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_CMPGE = 3'd1,
    OP_MOV   = 3'd2,
    OP_SEL   = 3'd3,
    OP_LDI   = 3'd4,
    OP_RD5   = 3'd5,
    OP_RD6   = 3'd6,
    OP_RD7   = 3'd7
  } op_e;

  function automatic logic op_writes(input logic [2:0] op);
    return (op <= 3'd4);
  endfunction
endpackage

// File: rtl/psu_lane_alu.sv
module psu_lane_alu import psu_pkg::*; #(
  parameter int LANE_W = 16
) (
  input  logic [2:0]        op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] imm,
  output logic [LANE_W-1:0] res,
  output logic              ge
);
  logic [LANE_W-1:0] sum;

  assign sum = a + b;
  assign ge  = (a >= b);

  always_comb begin
    case (op)
      OP_ADD:   res = sum;
      OP_CMPGE: res = {LANE_W{ge}};
      OP_LDI:   res = imm;
      default:  res = a;
    endcase
  end
endmodule

// File: rtl/psu_lane_gate.sv
module psu_lane_gate import psu_pkg::*; #(
  parameter int LANE_W = 16
) (
  input  logic [2:0]        op,
  input  logic [1:0]        cond,
  input  logic              flag,
  input  logic [LANE_W-1:0] mask,
  input  logic [LANE_W-1:0] res,
  input  logic [LANE_W-1:0] old,
  output logic [LANE_W-1:0] merged
);
  logic              pass;
  logic [LANE_W-1:0] wbits;

  assign pass = cond[1] | (cond[0] == flag);

  always_comb begin
    if (!pass)
      wbits = '0;
    else if (op == OP_SEL)
      wbits = mask;
    else
      wbits = '1;
  end

  assign merged = (res & wbits) | (old & ~wbits);
endmodule

// File: rtl/psu_vreg_file.sv
module psu_vreg_file #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  input  logic [AW-1:0]    rb_addr,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] ra_data,
  output logic [WIDTH-1:0] rb_data,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/psimd_lane_unit.sv
module psimd_lane_unit import psu_pkg::*; #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  parameter int NREGS  = 4,
  localparam int VW    = LANES * LANE_W,
  localparam int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_cond,
  input  logic [AW-1:0] in_dst,
  input  logic [AW-1:0] in_srca,
  input  logic [AW-1:0] in_srcb,
  input  logic [VW-1:0] in_imm,
  output logic          out_valid,
  output logic [VW-1:0] out_data,
  output logic [LANES-1:0] out_flags
);
  logic [VW-1:0]    va, vb, vd, vres, vmerged;
  logic [LANES-1:0] ge_vec;
  logic [LANES-1:0] flags_q;
  logic             wr_en;

  assign wr_en = in_valid & op_writes(in_op);

  psu_vreg_file #(.DEPTH(NREGS), .WIDTH(VW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (in_dst),
    .wdata   (vmerged),
    .ra_addr (in_srca),
    .rb_addr (in_srcb),
    .rd_addr (in_dst),
    .ra_data (va),
    .rb_data (vb),
    .rd_data (vd)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    psu_lane_alu #(.LANE_W(LANE_W)) u_alu (
      .op  (in_op),
      .a   (va[l*LANE_W +: LANE_W]),
      .b   (vb[l*LANE_W +: LANE_W]),
      .imm (in_imm[l*LANE_W +: LANE_W]),
      .res (vres[l*LANE_W +: LANE_W]),
      .ge  (ge_vec[l])
    );
    psu_lane_gate #(.LANE_W(LANE_W)) u_gate (
      .op     (in_op),
      .cond   (in_cond),
      .flag   (flags_q[l]),
      .mask   (vb[l*LANE_W +: LANE_W]),
      .res    (vres[l*LANE_W +: LANE_W]),
      .old    (vd[l*LANE_W +: LANE_W]),
      .merged (vmerged[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      flags_q   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= wr_en ? vmerged : vd;
        if (in_op == OP_CMPGE) flags_q <= ge_vec;
      end
    end
  end

  assign out_flags = flags_q;
endmodule

// File: rtl/psimd_lane_unit_chk.sv
module psimd_lane_unit_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  parameter int NREGS  = 4,
  localparam int VW    = LANES * LANE_W,
  localparam int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       in_op,
  input logic [1:0]       in_cond,
  input logic [AW-1:0]    in_srca,
  input logic [AW-1:0]    in_srcb,
  input logic [VW-1:0]    in_imm,
  input logic             out_valid,
  input logic [VW-1:0]    out_data,
  input logic [LANES-1:0] out_flags
);
  function automatic logic [VW-1:0] lane_mask(input logic [LANES-1:0] f);
    logic [VW-1:0] m;
    for (int l = 0; l < LANES; l++) m[l*LANE_W +: LANE_W] = {LANE_W{f[l]}};
    return m;
  endfunction

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R10
  AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_flags)));  // R10
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != 3'd1) |=> $stable(out_flags));  // R6
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd4 && in_cond[1]) |=> (out_data == $past(in_imm)));  // R2
  AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd1 && in_cond[1]) |=> (out_data == lane_mask(out_flags)));  // R4
  AST_CMP_SELF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd1 && in_srca == in_srcb) |=> (&out_flags));  // R4
endmodule

bind psimd_lane_unit psimd_lane_unit_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .NREGS(NREGS)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_cond(in_cond),
  .in_srca(in_srca), .in_srcb(in_srcb), .in_imm(in_imm),
  .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags)
);

// File: tb/psimd_lane_unit_tb.sv
module psimd_lane_unit_tb;
  localparam int L = 8;
  localparam int W = 16;
  localparam int VW = L * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_op = '0;
  logic [1:0]    in_cond = '0;
  logic [1:0]    in_dst = '0, in_srca = '0, in_srcb = '0;
  logic [VW-1:0] in_imm = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;
  logic [L-1:0]  out_flags;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [VW-1:0] m_reg [4];
  logic [L-1:0]  m_flag;
  logic [31:0]   seed = 32'h1234_5678;

  always #5 clk = ~clk;

  psimd_lane_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_cond(in_cond),
    .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb), .in_imm(in_imm),
    .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags)
  );

  function automatic logic [31:0] nx(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, check at the next falling edge.
  task automatic do_op(input string tag, input logic [2:0] op, input logic [1:0] cond,
                       input logic [1:0] d, input logic [1:0] a, input logic [1:0] b,
                       input logic [VW-1:0] imm);
    logic [VW-1:0] old, va, vb, nv;
    logic [L-1:0]  nf;
    old = m_reg[d]; va = m_reg[a]; vb = m_reg[b]; nv = old; nf = m_flag;
    for (int l = 0; l < L; l++) begin
      logic [W-1:0] la, lb, lo, ln;
      logic pass;
      la = va[l*W +: W]; lb = vb[l*W +: W]; lo = old[l*W +: W];
      pass = cond[1] || (cond[0] == m_flag[l]);
      case (op)
        3'd0: ln = W'((32'(la) + 32'(lb)) % 32'h10000);
        3'd1: ln = (la >= lb) ? 16'hFFFF : 16'h0000;
        3'd2: ln = la;
        3'd3: ln = (la & lb) | (lo & ~lb);
        3'd4: ln = imm[l*W +: W];
        default: ln = lo;
      endcase
      if (op == 3'd1) nf[l] = (la >= lb);
      nv[l*W +: W] = pass ? ln : lo;
    end
    if (op <= 3'd4) m_reg[d] = nv;
    m_flag = nf;
    in_valid = 1'b1; in_op = op; in_cond = cond; in_dst = d;
    in_srca = a; in_srcb = b; in_imm = imm;
    @(negedge clk);
    check({tag, " valid"}, VW'(out_valid), VW'(1'b1));
    check({tag, " data"}, out_data, nv);
    check({tag, " flags"}, VW'(out_flags), VW'(nf));
  endtask

  task automatic idle(input string tag);
    logic [VW-1:0] pd;
    logic [L-1:0] pf;
    pd = out_data; pf = out_flags;
    in_valid = 1'b0;
    in_op = 3'd4; in_cond = 2'b10; in_imm = {VW{1'b1}};
    @(negedge clk);
    check({tag, " valid low"}, VW'(out_valid), '0);
    check({tag, " data hold"}, out_data, pd);
    check({tag, " flags hold"}, VW'(out_flags), VW'(pf));
  endtask

  function automatic logic [VW-1:0] rep(input logic [W-1:0] v);
    return {L{v}};
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < 4; i++) begin
      seed = nx(seed);
      v[i*32 +: 32] = seed;
    end
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_flag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 valid", VW'(out_valid), '0);
    check("R1 data", out_data, '0);
    check("R1 flags", VW'(out_flags), '0);
    for (int r = 0; r < 4; r++) do_op("R1 read", 3'd5, 2'b00, 2'(r), 2'd0, 2'd0, '0);
    idle("R10");

    // R2: loads
    do_op("R2", 3'd4, 2'b10, 2'd0, 2'd0, 2'd0, rep(16'hFFFF));
    do_op("R2", 3'd4, 2'b11, 2'd1, 2'd0, 2'd0, rep(16'h0001));
    do_op("R2", 3'd4, 2'b10, 2'd2, 2'd0, 2'd0,
          128'h0007_0006_0005_0004_0003_0002_0001_0000);
    do_op("R2", 3'd4, 2'b10, 2'd3, 2'd0, 2'd0,
          128'h8000_7FFF_0000_FFFF_1234_8001_0003_0004);
    // R3: wrap per lane, no carry
    do_op("R3", 3'd0, 2'b10, 2'd0, 2'd0, 2'd1, '0);
    check("R3 wrap", out_data, '0);
    do_op("R3", 3'd0, 2'b10, 2'd1, 2'd3, 2'd3, '0);
    // R4: unsigned compare, equal/greater/less lanes
    do_op("R4", 3'd1, 2'b10, 2'd0, 2'd3, 2'd2, '0);
    do_op("R4", 3'd1, 2'b00, 2'd1, 2'd2, 2'd3, '0);
    do_op("R4", 3'd1, 2'b01, 2'd1, 2'd3, 2'd3, '0);
    check("R4 self", VW'(out_flags), VW'(8'hFF));
    // R5/R6: condition sweep after a mixed flag pattern
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 4; c++) begin
        do_op("R4 setup", 3'd4, 2'b10, 2'd2, 2'd0, 2'd0,
              128'h0000_FFFF_0000_FFFF_0001_0000_8000_7FFF);
        do_op("R4 setup", 3'd4, 2'b10, 2'd3, 2'd0, 2'd0,
              128'h0001_FFFE_0000_0000_0001_0001_7FFF_8000);
        do_op("R5 flags", 3'd1, 2'b10, 2'd0, 2'd2, 2'd3, '0);
        do_op("R5", 3'(op), 2'(c), 2'd1, 2'd2, 2'd3, rep(16'hA5C3));
        do_op("R6 read", 3'd5, 2'b00, 2'd1, 2'd0, 2'd0, '0);
      end
    // R7: select with bit mask
    do_op("R7", 3'd4, 2'b10, 2'd0, 2'd0, 2'd0, rep(16'hAAAA));
    do_op("R7", 3'd4, 2'b10, 2'd1, 2'd0, 2'd0, rep(16'h5555));
    do_op("R7", 3'd4, 2'b10, 2'd2, 2'd0, 2'd0, rep(16'h0FF0));
    do_op("R7", 3'd3, 2'b10, 2'd1, 2'd0, 2'd2, '0);
    check("R7 bits", out_data, rep(16'h5AA5));
    // R8: move
    do_op("R8", 3'd2, 2'b11, 2'd3, 2'd1, 2'd0, '0);
    // R9: read codes do not write
    do_op("R9", 3'd6, 2'b10, 2'd3, 2'd0, 2'd0, '0);
    do_op("R9", 3'd7, 2'b10, 2'd3, 2'd0, 2'd0, '0);
    idle("R10");
    do_op("R10 read", 3'd5, 2'b10, 2'd3, 2'd0, 2'd0, '0);

    // R11: A=A+B; where A>=C, A=D, checked arithmetically
    begin
      logic [VW-1:0] va, vb, vc, vd, ex;
      va = 128'hFFF0_0010_8000_0000_1234_7FFF_0001_FFFF;
      vb = 128'h0020_0010_8000_0005_0000_0001_0001_0001;
      vc = 128'h0010_0020_0000_0006_1234_8000_0003_0000;
      vd = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
      for (int l = 0; l < L; l++) begin
        logic [W-1:0] s;
        s = va[l*W +: W] + vb[l*W +: W];
        ex[l*W +: W] = (s >= vc[l*W +: W]) ? vd[l*W +: W] : s;
      end
      do_op("R11", 3'd4, 2'b10, 2'd0, 2'd0, 2'd0, va);
      do_op("R11", 3'd4, 2'b10, 2'd1, 2'd0, 2'd0, vb);
      do_op("R11", 3'd4, 2'b10, 2'd2, 2'd0, 2'd0, vc);
      do_op("R11", 3'd4, 2'b10, 2'd3, 2'd0, 2'd0, vd);
      do_op("R11", 3'd0, 2'b10, 2'd0, 2'd0, 2'd1, '0);
      do_op("R11", 3'd1, 2'b10, 2'd1, 2'd0, 2'd2, '0);
      do_op("R11", 3'd2, 2'b01, 2'd0, 2'd3, 2'd0, '0);
      check("R11 result", out_data, ex);
    end

    // Random stream, all codes, conditions and aliasing (R3 R4 R5 R6 R7)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      seed = nx(seed); r = seed;
      if (r[20:17] == 4'd0) idle("R10 rnd");
      else do_op("R5 rnd", r[2:0], r[4:3], r[6:5], r[8:7], r[10:9], rnd_vec());
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule